// File: doc/BRIEF.md
# Inter-port semaphore unit

This block holds a small bank of hardware token flags that two independent ports, called left and right, share in order to agree on which side may use a common resource. Each port selects one flag with a three-bit index and either writes a request or a release, or reads back the flag's state. A write never grants anything directly. It only registers the port's wish. The unit arbitrates between the two sides, and a port learns whether it won by reading the flag afterwards.

A port that asks for a flag held by the other side is remembered as waiting. When the holder gives the flag up, the token moves straight to the waiting side on the following clock edge, so the waiting port does not have to ask again. Semaphore accesses are only honoured while the port's memory enable is inactive. The combination of semaphore select together with an active memory enable is treated as illegal and leaves everything untouched.

All state sits in one clock domain with a synchronous active-high reset. Read results are combinational from the registered flag state, and write effects land on the rising clock edge.

Top module: `sem_exchange`

## Requirements
- R1: After reset every flag is free, and a legal read of any index on either port returns 8'hFF.
- R2: A port performs a semaphore access only while its select input `*_sel_n` is 0 and its memory enable `*_mem_en_n` is 1. With `*_sel_n` at 1, writes change no flag and the read bus is not driven.
- R3: A legal read (`*_rw` = 1, `*_oe_n` = 0) drives `*_dout_en` to 1 and puts the flag's state on all eight bits of `*_dout`: 8'h00 when this port holds the flag and 8'hFF otherwise. In any other cycle `*_dout_en` is 0 and `*_dout` is 8'h00. Output enable has no effect on writes.
- R4: With `*_sel_n` = 0 and `*_mem_en_n` = 0 at the same time, the port changes no flag and no waiting state, and `*_dout_en` stays 0.
- R5: A legal write (`*_rw` = 0) acts on the flag chosen by `*_idx[2:0]` and takes its value from `*_din[0]` alone: 0 requests the flag, 1 releases it. Bits 7 to 1 are ignored and the other seven flags are unaffected.
- R6: At most one port holds a given flag at any time. The holder reads 0 and every other port reads 1.
- R7: When both ports request the same free flag in the same cycle, the left port receives it and the right port's request is kept as waiting.
- R8: When the holder releases a flag that the other port is waiting for, the other port holds it from the next clock edge.
- R9: A release written by a port that does not hold the flag only withdraws that port's own waiting request and leaves the holder unchanged.
- R10: A request for a flag held by the other port is kept as waiting until it is granted or withdrawn, and a request by the holder itself changes nothing.
- R11: A write takes effect at the rising clock edge that ends its cycle: reads in the same cycle still return the old state, and reads from the next cycle on return the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_mem_en_n | input | 1 | Left memory enable, active low |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_idx | input | 3 | Left flag index |
| l_din | input | 8 | Left write data (bit 0 used) |
| l_dout | output | 8 | Left read data |
| l_dout_en | output | 1 | Left read bus driven |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_mem_en_n | input | 1 | Right memory enable, active low |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_idx | input | 3 | Right flag index |
| r_din | input | 8 | Right write data (bit 0 used) |
| r_dout | output | 8 | Right read data |
| r_dout_en | output | 1 | Right read bus driven |

## Verification
Read results are due in the same cycle as the read request, because they come combinationally from the registered flags, while a request, release or handoff is due one edge after the write cycle. The bench therefore changes its inputs on the falling edge and samples both read buses 1 ns later, still before the rising edge. Its reference model of holders and waiting requests is advanced on that rising edge, so every comparison sees the state left by all earlier writes and none of the current one. A directed sequence covers ties, handoffs and withdrawals, and a long pseudo-random sweep over both ports, including illegal and deselected accesses, is compared cycle by cycle against the model.

// File: rtl/sem_pkg.sv
package sem_pkg;

    // Holder of one flag
    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    // Kind of access a port presents in a cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_CLASH = 2'b11
    } access_e;

    // Registered state of one flag
    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } flag_state_t;

    // Per-flag command from one port in one cycle
    typedef struct packed {
        logic claim;
        logic drop;
    } flag_cmd_t;

    localparam flag_state_t FLAG_RESET = '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};

    // Decode the port strobes into an access kind
    function automatic access_e classify(input logic sel_n, input logic mem_en_n,
                                         input logic rw, input logic out_en_n);
        if (sel_n)     return ACC_NONE;
        if (!mem_en_n) return ACC_CLASH;
        if (!rw)       return ACC_WRITE;
        if (!out_en_n) return ACC_READ;
        return ACC_NONE;
    endfunction

    // Next state of one flag given both ports' commands.
    // A holder that does not drop keeps the flag; otherwise the left
    // side wins among the wishing ports and the loser keeps waiting.
    function automatic flag_state_t arbitrate(input flag_state_t cur,
                                              input flag_cmd_t lc,
                                              input flag_cmd_t rc);
        flag_state_t nxt;
        logic held_l, held_r, keep_l, keep_r, want_l, want_r;
        held_l = (cur.owner == OWN_LEFT);
        held_r = (cur.owner == OWN_RIGHT);
        keep_l = held_l && !lc.drop;
        keep_r = held_r && !rc.drop;
        want_l = !held_l && !lc.drop && (cur.wait_l || lc.claim);
        want_r = !held_r && !rc.drop && (cur.wait_r || rc.claim);
        nxt = FLAG_RESET;
        if (keep_l) begin
            nxt.owner  = OWN_LEFT;
            nxt.wait_r = want_r;
        end else if (keep_r) begin
            nxt.owner  = OWN_RIGHT;
            nxt.wait_l = want_l;
        end else if (want_l) begin
            nxt.owner  = OWN_LEFT;
            nxt.wait_r = want_r;
        end else if (want_r) begin
            nxt.owner  = OWN_RIGHT;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                               sel_n,
    input  logic                               mem_en_n,
    input  logic                               rw,
    input  logic                               oe_n,
    input  logic [ADDR_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                  din,
    output flag_cmd_t [NUM_FLAGS-1:0]          cmd_vec,
    output logic                               rd_en
);

    access_e acc;
    logic    is_wr;
    logic    unused_din_hi;

    assign acc           = classify(sel_n, mem_en_n, rw, oe_n);
    assign is_wr         = (acc == ACC_WRITE);
    assign rd_en         = (acc == ACC_READ);
    assign unused_din_hi = ^din[DATA_W-1:1];

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_hit
        logic hit;
        assign hit              = (idx == ADDR_W'(k));
        assign cmd_vec[k].claim = is_wr && hit && !din[0];
        assign cmd_vec[k].drop  = is_wr && hit &&  din[0];
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  flag_cmd_t   cmd_l,
    input  flag_cmd_t   cmd_r,
    output flag_state_t state
);

    flag_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLAG_RESET;
        end else begin
            state_q <= arbitrate(state_q, cmd_l, cmd_r);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic [NUM_FLAGS-1:0] held_vec,
    input  logic [ADDR_W-1:0]    idx,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    dout,
    output logic                 dout_en
);

    logic flag_bit;

    always_comb begin
        flag_bit = 1'b1;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            if (idx == ADDR_W'(k)) flag_bit = !held_vec[k];
        end
    end

    assign dout    = rd_en ? {DATA_W{flag_bit}} : '0;
    assign dout_en = rd_en;

endmodule

// File: rtl/sem_exchange.sv
module sem_exchange
    import sem_pkg::*;
#(
    parameter  int NUM_FLAGS = 8,
    parameter  int DATA_W    = 8,
    localparam int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_mem_en_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_idx,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dout_en,
    input  logic              r_sel_n,
    input  logic              r_mem_en_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_idx,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dout_en
);

    flag_cmd_t   [NUM_FLAGS-1:0] cmd_l;
    flag_cmd_t   [NUM_FLAGS-1:0] cmd_r;
    flag_state_t [NUM_FLAGS-1:0] flag_st;
    logic        [NUM_FLAGS-1:0] own_l_vec;
    logic        [NUM_FLAGS-1:0] own_r_vec;
    logic        [NUM_FLAGS-1:0] wait_l_vec;
    logic        [NUM_FLAGS-1:0] wait_r_vec;
    logic                        rd_l;
    logic                        rd_r;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_l (
        .sel_n    (l_sel_n),
        .mem_en_n (l_mem_en_n),
        .rw       (l_rw),
        .oe_n     (l_oe_n),
        .idx      (l_idx),
        .din      (l_din),
        .cmd_vec  (cmd_l),
        .rd_en    (rd_l)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_r (
        .sel_n    (r_sel_n),
        .mem_en_n (r_mem_en_n),
        .rw       (r_rw),
        .oe_n     (r_oe_n),
        .idx      (r_idx),
        .din      (r_din),
        .cmd_vec  (cmd_r),
        .rd_en    (rd_r)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        sem_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .cmd_l (cmd_l[k]),
            .cmd_r (cmd_r[k]),
            .state (flag_st[k])
        );
        assign own_l_vec[k]  = (flag_st[k].owner == OWN_LEFT);
        assign own_r_vec[k]  = (flag_st[k].owner == OWN_RIGHT);
        assign wait_l_vec[k] = flag_st[k].wait_l;
        assign wait_r_vec[k] = flag_st[k].wait_r;
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_l (
        .held_vec (own_l_vec),
        .idx      (l_idx),
        .rd_en    (rd_l),
        .dout     (l_dout),
        .dout_en  (l_dout_en)
    );

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_r (
        .held_vec (own_r_vec),
        .idx      (r_idx),
        .rd_en    (rd_r),
        .dout     (r_dout),
        .dout_en  (r_dout_en)
    );

endmodule

// File: rtl/sem_exchange_chk.sv
module sem_exchange_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 l_sel_n,
    input logic                 l_mem_en_n,
    input logic                 l_rw,
    input logic [ADDR_W-1:0]    l_idx,
    input logic [DATA_W-1:0]    l_din,
    input logic [DATA_W-1:0]    l_dout,
    input logic                 l_dout_en,
    input logic                 r_sel_n,
    input logic                 r_mem_en_n,
    input logic                 r_rw,
    input logic [ADDR_W-1:0]    r_idx,
    input logic [DATA_W-1:0]    r_din,
    input logic [DATA_W-1:0]    r_dout,
    input logic                 r_dout_en,
    input logic [NUM_FLAGS-1:0] own_l_vec,
    input logic [NUM_FLAGS-1:0] own_r_vec,
    input logic [NUM_FLAGS-1:0] wait_l_vec,
    input logic [NUM_FLAGS-1:0] wait_r_vec
);

    logic l_wr, r_wr, l_clash;
    assign l_wr    = !l_sel_n && l_mem_en_n && !l_rw;
    assign r_wr    = !r_sel_n && r_mem_en_n && !r_rw;
    assign l_clash = !l_sel_n && !l_mem_en_n;

    // R6: never two holders of one flag
    p_excl_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (own_l_vec & own_r_vec) == '0);

    // R3: a driven read bus carries one value replicated on every line
    p_replicate_r3: assert property (@(posedge clk) disable iff (rst)
        (l_dout_en |-> (l_dout == '0 || l_dout == '1)) and
        (r_dout_en |-> (r_dout == '0 || r_dout == '1)));

    // R3: an undriven bus reads zero
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (!l_dout_en |-> l_dout == '0) and (!r_dout_en |-> r_dout == '0));

    // R4: an illegal access does not drive and changes nothing
    p_clash_nodrive_r4: assert property (@(posedge clk) disable iff (rst)
        l_clash |-> !l_dout_en);

    p_clash_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (l_clash && r_sel_n) |=> ($stable(own_l_vec) && $stable(own_r_vec) &&
                                  $stable(wait_l_vec) && $stable(wait_r_vec)));

    // R7: simultaneous requests on a free flag favour the left port
    p_tie_left_r7: assert property (@(posedge clk) disable iff (rst)
        (l_wr && r_wr && !l_din[0] && !r_din[0] && l_idx == r_idx &&
         !own_l_vec[l_idx] && !own_r_vec[l_idx])
        |=> (own_l_vec[$past(l_idx)] && wait_r_vec[$past(l_idx)]));

    // R8: release by the holder hands the flag to the waiting side
    p_handoff_r8: assert property (@(posedge clk) disable iff (rst)
        (l_wr && l_din[0] && own_l_vec[l_idx] && wait_r_vec[l_idx] && r_sel_n)
        |=> own_r_vec[$past(l_idx)]);

    // R9: a non-holder release leaves the holder in place
    p_foreign_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (r_wr && r_din[0] && own_l_vec[r_idx] && l_sel_n)
        |=> (own_l_vec[$past(r_idx)] && !wait_r_vec[$past(r_idx)]));

endmodule

bind sem_exchange sem_exchange_chk #(
    .NUM_FLAGS (NUM_FLAGS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .l_sel_n    (l_sel_n),
    .l_mem_en_n (l_mem_en_n),
    .l_rw       (l_rw),
    .l_idx      (l_idx),
    .l_din      (l_din),
    .l_dout     (l_dout),
    .l_dout_en  (l_dout_en),
    .r_sel_n    (r_sel_n),
    .r_mem_en_n (r_mem_en_n),
    .r_rw       (r_rw),
    .r_idx      (r_idx),
    .r_din      (r_din),
    .r_dout     (r_dout),
    .r_dout_en  (r_dout_en),
    .own_l_vec  (own_l_vec),
    .own_r_vec  (own_r_vec),
    .wait_l_vec (wait_l_vec),
    .wait_r_vec (wait_r_vec)
);

// File: tb/test_sem_exchange.sv
`timescale 1ns/1ps
module test_sem_exchange;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       l_sel_n = 1'b1, l_mem_en_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1;
    logic [2:0] l_idx = '0;
    logic [7:0] l_din = '0;
    logic [7:0] l_dout;
    logic       l_dout_en;
    logic       r_sel_n = 1'b1, r_mem_en_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1;
    logic [2:0] r_idx = '0;
    logic [7:0] r_din = '0;
    logic [7:0] r_dout;
    logic       r_dout_en;

    int checks = 0;
    int errors = 0;

    bit m_own  [2][8];
    bit m_wait [2][8];

    always #2.5 clk = ~clk;

    sem_exchange i_sem_exchange (
        .clk(clk), .rst(rst),
        .l_sel_n(l_sel_n), .l_mem_en_n(l_mem_en_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
        .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout), .l_dout_en(l_dout_en),
        .r_sel_n(r_sel_n), .r_mem_en_n(r_mem_en_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
        .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout), .r_dout_en(r_dout_en)
    );

    // Reference model: releases first, then new requests, then grant (left first)
    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 8; k++) begin
                    m_own[p][k]  = 1'b0;
                    m_wait[p][k] = 1'b0;
                end
        end else begin
            bit wl, wr;
            wl = !l_sel_n && l_mem_en_n && !l_rw;
            wr = !r_sel_n && r_mem_en_n && !r_rw;
            for (int k = 0; k < 8; k++) begin
                bit ql, dl, qr, dr;
                ql = wl && (l_idx == 3'(k)) && !l_din[0];
                dl = wl && (l_idx == 3'(k)) &&  l_din[0];
                qr = wr && (r_idx == 3'(k)) && !r_din[0];
                dr = wr && (r_idx == 3'(k)) &&  r_din[0];
                if (dl) begin
                    if (m_own[0][k]) m_own[0][k] = 1'b0; else m_wait[0][k] = 1'b0;
                end
                if (dr) begin
                    if (m_own[1][k]) m_own[1][k] = 1'b0; else m_wait[1][k] = 1'b0;
                end
                if (ql && !m_own[0][k]) m_wait[0][k] = 1'b1;
                if (qr && !m_own[1][k]) m_wait[1][k] = 1'b1;
                if (!m_own[0][k] && !m_own[1][k]) begin
                    if (m_wait[0][k]) begin
                        m_own[0][k] = 1'b1; m_wait[0][k] = 1'b0;
                    end else if (m_wait[1][k]) begin
                        m_own[1][k] = 1'b1; m_wait[1][k] = 1'b0;
                    end
                end
            end
        end
    end

    // op: 0 idle, 1 read, 2 write, 3 illegal write, 4 illegal read,
    //     5 read with output disabled, 6 deselected write, 7 write with oe low
    task automatic drive(input int side, input int op, input logic [2:0] idx, input logic [7:0] d);
        logic s, m, w, o;
        case (op)
            1: begin s = 0; m = 1; w = 1; o = 0; end
            2: begin s = 0; m = 1; w = 0; o = 1; end
            3: begin s = 0; m = 0; w = 0; o = 1; end
            4: begin s = 0; m = 0; w = 1; o = 0; end
            5: begin s = 0; m = 1; w = 1; o = 1; end
            6: begin s = 1; m = 1; w = 0; o = 1; end
            7: begin s = 0; m = 1; w = 0; o = 0; end
            default: begin s = 1; m = 1; w = 1; o = 1; end
        endcase
        if (side == 0) begin
            l_sel_n = s; l_mem_en_n = m; l_rw = w; l_oe_n = o; l_idx = idx; l_din = d;
        end else begin
            r_sel_n = s; r_mem_en_n = m; r_rw = w; r_oe_n = o; r_idx = idx; r_din = d;
        end
    endtask

    task automatic check_exp(input int side, input logic exp_en, input logic [7:0] exp_d,
                             input string tag);
        logic       en;
        logic [7:0] d;
        en = (side == 0) ? l_dout_en : r_dout_en;
        d  = (side == 0) ? l_dout    : r_dout;
        checks++;
        if (en !== exp_en || d !== exp_d) begin
            errors++;
            $display("FAIL %s port %0d: got en=%b data=%h, expected en=%b data=%h",
                     tag, side, en, d, exp_en, exp_d);
        end
    endtask

    task automatic check_model(input int side, input string tag);
        logic       rd;
        logic [2:0] ix;
        if (side == 0) begin
            rd = !l_sel_n && l_mem_en_n && l_rw && !l_oe_n; ix = l_idx;
        end else begin
            rd = !r_sel_n && r_mem_en_n && r_rw && !r_oe_n; ix = r_idx;
        end
        if (rd) check_exp(side, 1'b1, m_own[side][ix] ? 8'h00 : 8'hFF, tag);
        else    check_exp(side, 1'b0, 8'h00, tag);
    endtask

    // Inputs already set on the falling edge; sample, then advance one cycle
    task automatic step_check(input string tag);
        #1;
        check_model(0, tag);
        check_model(1, tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every flag free after reset
        for (int k = 0; k < 8; k++) begin
            drive(0, 1, 3'(k), 8'h00);
            drive(1, 1, 3'(7 - k), 8'h00);
            #1;
            check_exp(0, 1'b1, 8'hFF, "R1");
            check_exp(1, 1'b1, 8'hFF, "R1");
            step();
        end

        // R5: claim flag 3 with high data bits set; R11: same-cycle read sees old state
        drive(0, 2, 3'd3, 8'hFE);
        drive(1, 1, 3'd3, 8'h00);
        #1; check_exp(1, 1'b1, 8'hFF, "R11");
        step();
        drive(0, 1, 3'd3, 8'h00);
        drive(1, 1, 3'd3, 8'h00);
        #1;
        check_exp(0, 1'b1, 8'h00, "R5");
        check_exp(1, 1'b1, 8'hFF, "R6");
        step();
        drive(0, 1, 3'd2, 8'h00);
        #1; check_exp(0, 1'b1, 8'hFF, "R5");
        step();

        // R2: deselected write has no effect
        drive(0, 0, 3'd0, 8'h00);
        drive(1, 6, 3'd5, 8'h00);
        #1; check_exp(1, 1'b0, 8'h00, "R2");
        step();
        drive(1, 1, 3'd5, 8'h00);
        #1; check_exp(1, 1'b1, 8'hFF, "R2");
        step();

        // R4: illegal write and read
        drive(1, 3, 3'd6, 8'h00);
        #1; check_exp(1, 1'b0, 8'h00, "R4");
        step();
        drive(1, 4, 3'd6, 8'h00);
        #1; check_exp(1, 1'b0, 8'h00, "R4");
        step();
        drive(1, 1, 3'd6, 8'h00);
        #1; check_exp(1, 1'b1, 8'hFF, "R4");
        step();

        // R3: output enable high gives no drive
        drive(0, 5, 3'd3, 8'h00);
        #1; check_exp(0, 1'b0, 8'h00, "R3");
        step();

        // R10: right asks for flag 3 held by left, stays waiting
        drive(1, 2, 3'd3, 8'h00);
        step();
        drive(1, 1, 3'd3, 8'h00);
        drive(0, 2, 3'd3, 8'h00);  // holder asks again: no change
        #1; check_exp(1, 1'b1, 8'hFF, "R10");
        step();
        drive(0, 1, 3'd3, 8'h00);
        #1; check_exp(0, 1'b1, 8'h00, "R10");
        step();

        // R8: left releases (only bit 0 matters), right takes over next cycle
        drive(0, 2, 3'd3, 8'h01);
        drive(1, 0, 3'd0, 8'h00);
        step();
        drive(0, 1, 3'd3, 8'h00);
        drive(1, 1, 3'd3, 8'h00);
        #1;
        check_exp(1, 1'b1, 8'h00, "R8");
        check_exp(0, 1'b1, 8'hFF, "R8");
        step();

        // R9: left waits, then withdraws; right release then frees the flag
        drive(1, 0, 3'd0, 8'h00);
        drive(0, 2, 3'd3, 8'h80);
        step();
        drive(0, 2, 3'd3, 8'h01);
        step();
        drive(0, 1, 3'd3, 8'h00);
        drive(1, 1, 3'd3, 8'h00);
        #1; check_exp(1, 1'b1, 8'h00, "R9");
        step();
        drive(0, 0, 3'd0, 8'h00);
        drive(1, 2, 3'd3, 8'hFF);
        step();
        drive(0, 1, 3'd3, 8'h00);
        drive(1, 1, 3'd3, 8'h00);
        #1;
        check_exp(0, 1'b1, 8'hFF, "R9");
        check_exp(1, 1'b1, 8'hFF, "R9");
        step();

        // R7: tie on flag 4, then handoff to the waiting right port
        drive(0, 2, 3'd4, 8'h00);
        drive(1, 2, 3'd4, 8'h00);
        step();
        drive(0, 1, 3'd4, 8'h00);
        drive(1, 1, 3'd4, 8'h00);
        #1;
        check_exp(0, 1'b1, 8'h00, "R7");
        check_exp(1, 1'b1, 8'hFF, "R7");
        step();
        drive(0, 7, 3'd4, 8'h01);
        drive(1, 0, 3'd0, 8'h00);
        step();
        drive(1, 1, 3'd4, 8'h00);
        #1; check_exp(1, 1'b1, 8'h00, "R7");
        step();

        // R6 sweep: pseudo-random traffic on both ports, narrow then full index range
        lfsr = 32'h1ACE_B00C;
        for (int c = 0; c < 6000; c++) begin
            logic [2:0] mask;
            mask = (c < 3000) ? 3'b001 : 3'b111;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(0, int'(lfsr[2:0]), lfsr[5:3] & mask, lfsr[13:6]);
            drive(1, int'(lfsr[16:14]), lfsr[19:17] & mask, lfsr[27:20]);
            step_check("R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule